// File: doc/BRIEF.md
# ADC Control and SAR Sequencer

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter. Software reaches it through a small register bus: a control/status register and a read-only result register. It drives a trial code to an external DAC, samples a single-bit comparator that reports whether the analog input is at or above that code, and builds the result one bit at a time from the most significant bit down. When a conversion ends it latches the result, raises a done flag and, if enabled, an interrupt request.

Software clears the power-down bit with one write, then starts each conversion with a separate write of the start bit. There is no continuous mode. A start written during a conversion abandons it and begins again from the first trial. Setting power-down during a conversion stops it without a result. The done flag is the interrupt condition, so a fresh start also clears the interrupt.

Register map (address width 1): address 0 is control/status, address 1 is the result. Control bits: bit 0 power-down (1 = off), bit 1 interrupt enable, bit 2 start (write-only), bit 3 done (read-only). Bits 7..4 read as 0.

Top module: `adc_sar_top`

## Requirements
- R1: After reset the control register reads 01h (powered down, interrupt disabled, done 0), the result register reads 00h, irqReq is 0 and dacCode is 00h.
- R2: A start write is ignored when power-down is currently 1 or the same write sets bit 0. No conversion runs and done stays 0.
- R3: An accepted start clears done at the write edge. Done reads 0 eight cycles after that edge and 1 nine cycles after it.
- R4: The first trial code after an accepted start is 80h. Trials go from MSB to LSB. A trial bit is kept only when cmpHigh is 1, so the result equals the largest code not above the comparator threshold.
- R5: Bit 2 of the control register always reads 0, including right after a start write and during a conversion.
- R6: A start write during a conversion abandons it and restarts from the first trial. Done rises nine cycles after the latest start, with the result of the restarted conversion.
- R7: A write that sets power-down during a conversion aborts it. Done stays 0 and the result register keeps its previous value.
- R8: irqReq is 1 exactly when done is 1 and the interrupt-enable bit (bit 1) is 1.
- R9: A comparator that always reports high gives FFh. One that always reports low gives 00h. No overflow indication exists.
- R10: After done is set, nothing changes until the next accepted start: done, the result register and dacCode stay constant.
- R11: Software writes cannot change done (bit 3) or the result register (address 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Register address: 0 control/status, 1 result |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | BUS_W | Write data |
| busRdData | output | BUS_W | Combinational read data for busAddr |
| cmpHigh | input | 1 | Comparator: input at or above dacCode |
| dacCode | output | RES_W | Trial code to the DAC |
| irqReq | output | 1 | Interrupt request, level |

## Verification
The bench uses the default parameters: RES_W = 8, BUS_W = 8 and ADDR_W = 1. With these values the bench sweeps all 256 comparator thresholds, including the 00h and FFh extremes, at an affordable cycle cost. The read path needs no padding at these widths, so every control and result bit appears directly on the bus. Random restarts and power-down aborts are placed at offsets that always fall inside the nine-cycle conversion window.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;

  // Register addresses
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_DATA = 1;

  // Control/status bit positions
  localparam int unsigned BIT_PD    = 0;
  localparam int unsigned BIT_IE    = 1;
  localparam int unsigned BIT_START = 2;
  localparam int unsigned BIT_DONE  = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic launch;   // clear accumulator, load MSB trial
    logic resolve;  // decide current trial bit, move to next
    logic commit;   // copy accumulator into result register
  } sarStrobe_t;

endpackage

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
  import adc_sar_pkg::*;
#(
  parameter int unsigned RES_W  = 8,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_W-1:0]  busWrData,
  output sarStrobe_t        strobe,
  output logic              pwrDown,
  output logic              irqEn,
  output logic              doneFlag,
  output logic [BUS_W-1:0]  ctrlRdData
);

  localparam int unsigned CNT_W = $clog2(RES_W + 1);
  localparam logic [CNT_W-1:0] STEP_LOAD = CNT_W'(RES_W);

  logic             busy;
  logic [CNT_W-1:0] stepsLeft;
  logic             ctrlWrite;
  logic             startAccept;
  logic             pdAbort;

  assign ctrlWrite   = busWrEn && (busAddr == ADDR_W'(ADDR_CTRL));
  assign pdAbort     = ctrlWrite && busWrData[BIT_PD];
  assign startAccept = ctrlWrite && busWrData[BIT_START]
                       && !busWrData[BIT_PD] && !pwrDown;

  // Register bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrDown <= 1'b1;
      irqEn   <= 1'b0;
    end else if (ctrlWrite) begin
      pwrDown <= busWrData[BIT_PD];
      irqEn   <= busWrData[BIT_IE];
    end
  end

  // Sequencer: start edge, RES_W resolve edges, one commit edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      doneFlag  <= 1'b0;
      stepsLeft <= '0;
    end else if (pdAbort) begin
      busy      <= 1'b0;
      stepsLeft <= '0;
    end else if (startAccept) begin
      busy      <= 1'b1;
      doneFlag  <= 1'b0;
      stepsLeft <= STEP_LOAD;
    end else if (busy) begin
      if (stepsLeft != '0) begin
        stepsLeft <= stepsLeft - 1'b1;
      end else begin
        busy     <= 1'b0;
        doneFlag <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.launch  = startAccept;
    strobe.resolve = busy && !pdAbort && !startAccept && (stepsLeft != '0);
    strobe.commit  = busy && !pdAbort && !startAccept && (stepsLeft == '0);
  end

  always_comb begin
    ctrlRdData            = '0;
    ctrlRdData[BIT_PD]    = pwrDown;
    ctrlRdData[BIT_IE]    = irqEn;
    ctrlRdData[BIT_START] = 1'b0;
    ctrlRdData[BIT_DONE]  = doneFlag;
  end

endmodule

// File: rtl/adc_sar_dp.sv
module adc_sar_dp
  import adc_sar_pkg::*;
#(
  parameter int unsigned RES_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  sarStrobe_t       strobe,
  input  logic             cmpHigh,
  output logic [RES_W-1:0] dacCode,
  output logic [RES_W-1:0] resultData
);

  localparam logic [RES_W-1:0] MSB_MASK = RES_W'(1) << (RES_W - 1);

  logic [RES_W-1:0] accBits;
  logic [RES_W-1:0] trialMask;
  logic [RES_W-1:0] keepBits;

  for (genvar i = 0; i < RES_W; i++) begin : g_keep
    assign keepBits[i] = trialMask[i] & cmpHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accBits   <= '0;
      trialMask <= '0;
    end else if (strobe.launch) begin
      accBits   <= '0;
      trialMask <= MSB_MASK;
    end else if (strobe.resolve) begin
      accBits   <= accBits | keepBits;
      trialMask <= trialMask >> 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultData <= '0;
    end else if (strobe.commit) begin
      resultData <= accBits;
    end
  end

  assign dacCode = accBits | trialMask;

endmodule

// File: rtl/adc_sar_top.sv
module adc_sar_top
  import adc_sar_pkg::*;
#(
  parameter int unsigned RES_W  = 8,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  input  logic              cmpHigh,
  output logic [RES_W-1:0]  dacCode,
  output logic              irqReq
);

  sarStrobe_t       strobe;
  logic             pwrDown;
  logic             irqEn;
  logic             doneFlag;
  logic [BUS_W-1:0] ctrlRdData;
  logic [RES_W-1:0] resultData;
  logic [BUS_W-1:0] dataRdData;

  adc_sar_ctrl #(.RES_W(RES_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .strobe    (strobe),
    .pwrDown   (pwrDown),
    .irqEn     (irqEn),
    .doneFlag  (doneFlag),
    .ctrlRdData(ctrlRdData)
  );

  adc_sar_dp #(.RES_W(RES_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmpHigh   (cmpHigh),
    .dacCode   (dacCode),
    .resultData(resultData)
  );

  if (BUS_W > RES_W) begin : g_pad
    assign dataRdData = {{(BUS_W - RES_W){1'b0}}, resultData};
  end else begin : g_fit
    assign dataRdData = resultData[BUS_W-1:0];
  end

  assign busRdData = (busAddr == ADDR_W'(ADDR_DATA)) ? dataRdData : ctrlRdData;
  assign irqReq    = doneFlag & irqEn;

endmodule

// File: rtl/adc_sar_chk.sv
module adc_sar_chk
  import adc_sar_pkg::*;
#(
  parameter int unsigned RES_W  = 8,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned ADDR_W = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [BUS_W-1:0]  busWrData,
  input logic [BUS_W-1:0]  busRdData,
  input logic [RES_W-1:0]  dacCode,
  input logic              irqReq,
  input logic              pwrDown,
  input logic              irqEn,
  input logic              doneFlag,
  input logic [RES_W-1:0]  resultData
);

  localparam logic [RES_W-1:0] FIRST_TRIAL = RES_W'(1) << (RES_W - 1);

  logic goWrite;
  assign goWrite = busWrEn && (busAddr == ADDR_W'(ADDR_CTRL))
                   && busWrData[BIT_START] && !busWrData[BIT_PD] && !pwrDown;

  p_pd_blocks_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |=> !$rose(doneFlag));

  p_start_clears_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    goWrite |=> !doneFlag);

  p_first_trial_r4: assert property (@(posedge clk) disable iff (!rstN)
    goWrite |=> (dacCode == FIRST_TRIAL));

  p_start_reads_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(ADDR_CTRL)) |-> !busRdData[BIT_START]);

  p_result_only_on_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resultData) |-> $rose(doneFlag));

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> ($rose(doneFlag) || $rose(irqEn)));

  p_done_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !goWrite) |=> doneFlag);

  p_code_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !goWrite) |=> $stable(dacCode));

endmodule

bind adc_sar_top adc_sar_chk #(.RES_W(RES_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .dacCode   (dacCode),
  .irqReq    (irqReq),
  .pwrDown   (pwrDown),
  .irqEn     (irqEn),
  .doneFlag  (doneFlag),
  .resultData(resultData)
);

// File: tb/tb_adc_sar_top.sv
module tb_adc_sar_top;

  localparam int RES_W = 8;
  localparam int BUS_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [0:0]       busAddr = '0;
  logic             busWrEn = 1'b0;
  logic [BUS_W-1:0] busWrData = '0;
  logic [BUS_W-1:0] busRdData;
  logic             cmpHigh;
  logic [RES_W-1:0] dacCode;
  logic             irqReq;
  logic [RES_W-1:0] target = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // Comparator model: input at or above trial code
  assign cmpHigh = (target >= dacCode);

  adc_sar_top #(.RES_W(RES_W), .BUS_W(BUS_W), .ADDR_W(1)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .cmpHigh(cmpHigh),
    .dacCode(dacCode), .irqReq(irqReq)
  );

  function automatic logic [7:0] expCode(input logic [7:0] thr);
    logic [7:0] acc = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      logic [7:0] trial = acc | (8'h01 << i);
      if (thr >= trial) acc = trial;
    end
    return acc;
  endfunction

  function automatic logic [7:0] ctrlWord(input bit pd, input bit ie, input bit go);
    return {5'b0, go, ie, pd};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic addr, input logic [7:0] data);
    @(negedge clk);
    busAddr = addr; busWrData = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0; busAddr = '0;
  endtask

  task automatic readReg(input logic addr, output logic [7:0] val);
    busAddr = addr;
    #1;
    val = busRdData;
    busAddr = '0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Full conversion with exact timing checks
  task automatic convert(input logic [7:0] thr, input bit ie, inout logic [7:0] lastData);
    logic [7:0] v;
    target = thr;
    writeReg(1'b0, ctrlWord(1'b0, ie, 1'b1));
    check("R4 first trial", dacCode, 8'h80);
    readReg(1'b0, v);
    check("R3 done cleared", v[3], 1'b0);
    check("R5 start reads 0", v[2], 1'b0);
    waitCycles(8);
    readReg(1'b0, v);
    check("R3 done not yet", v[3], 1'b0);
    waitCycles(1);
    readReg(1'b0, v);
    check("R3 done set", v[3], 1'b1);
    readReg(1'b1, v);
    check("R4 result", v, expCode(thr));
    check("R8 irq", irqReq, ie);
    lastData = v;
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] lastData;
    logic [7:0] codeHold;
    void'($urandom(32'h5a17_c0de));

    waitCycles(3);
    readReg(1'b0, v);  check("R1 ctrl reset", v, 8'h01);
    readReg(1'b1, v);  check("R1 data reset", v, 8'h00);
    check("R1 irq reset", irqReq, 1'b0);
    check("R1 dac reset", dacCode, 8'h00);
    rstN = 1'b1;
    waitCycles(1);
    readReg(1'b0, v);  check("R1 ctrl after release", v, 8'h01);
    lastData = 8'h00;

    // R2: start with power-down set in same write, then start while still off
    target = 8'h5A;
    writeReg(1'b0, ctrlWord(1'b1, 1'b1, 1'b1));
    writeReg(1'b0, ctrlWord(1'b0, 1'b1, 1'b1));
    waitCycles(12);
    readReg(1'b0, v);
    check("R2 no conversion", v, 8'h02);
    check("R2 dac idle", dacCode, 8'h00);
    check("R2 irq idle", irqReq, 1'b0);

    // R9 extremes, R8 irq with and without enable
    convert(8'hFF, 1'b1, lastData);
    check("R9 full scale", lastData, 8'hFF);
    convert(8'h00, 1'b0, lastData);
    check("R9 zero", lastData, 8'h00);
    convert(8'hA7, 1'b1, lastData);

    // R10: nothing moves after done
    codeHold = dacCode;
    target = 8'h13;
    waitCycles(20);
    readReg(1'b0, v);  check("R10 done held", v[3], 1'b1);
    readReg(1'b1, v);  check("R10 data held", v, lastData);
    check("R10 dac held", dacCode, codeHold);

    // R11: writes to done bit and data register have no effect
    writeReg(1'b1, 8'h3C);
    readReg(1'b1, v);  check("R11 data read-only", v, lastData);
    writeReg(1'b0, 8'h08);
    readReg(1'b0, v);  check("R11 done kept", v, 8'h08);
    check("R8 irq off with ie=0", irqReq, 1'b0);
    writeReg(1'b0, ctrlWord(1'b0, 1'b1, 1'b0));
    check("R8 irq on with ie=1", irqReq, 1'b1);

    // R6: restart mid-conversion
    target = 8'h21;
    writeReg(1'b0, ctrlWord(1'b0, 1'b1, 1'b1));
    check("R8 irq cleared by start", irqReq, 1'b0);
    waitCycles(3);
    convert(8'hC4, 1'b1, lastData);
    check("R6 restarted result", lastData, expCode(8'hC4));

    // R7: power-down abort
    target = 8'h77;
    writeReg(1'b0, ctrlWord(1'b0, 1'b1, 1'b1));
    waitCycles(4);
    writeReg(1'b0, ctrlWord(1'b1, 1'b1, 1'b0));
    waitCycles(12);
    readReg(1'b0, v);  check("R7 no done after abort", v, 8'h03);
    readReg(1'b1, v);  check("R7 data kept", v, lastData);
    writeReg(1'b0, ctrlWord(1'b0, 1'b1, 1'b0));
    waitCycles(12);
    readReg(1'b0, v);  check("R7 still not done", v[3], 1'b0);

    // R4/R9: sweep every threshold
    for (int t = 0; t < 256; t++) begin
      convert(8'(t), t[0], lastData);
    end

    // Random mix of restarts and aborts
    for (int n = 0; n < 150; n++) begin
      int mode = int'($urandom % 3);
      int gap  = int'($urandom % 6);
      bit ie   = 1'($urandom);
      logic [7:0] thr = 8'($urandom);
      if (mode == 0) begin
        convert(thr, ie, lastData);
      end else if (mode == 1) begin
        target = 8'($urandom);
        writeReg(1'b0, ctrlWord(1'b0, ie, 1'b1));
        waitCycles(gap);
        convert(thr, ie, lastData);
        check("R6 random restart", lastData, expCode(thr));
      end else begin
        target = thr;
        writeReg(1'b0, ctrlWord(1'b0, ie, 1'b1));
        waitCycles(gap);
        writeReg(1'b0, ctrlWord(1'b1, ie, 1'b0));
        waitCycles(10);
        readReg(1'b0, v);  check("R7 random abort done", v[3], 1'b0);
        readReg(1'b1, v);  check("R7 random abort data", v, lastData);
        check("R8 random abort irq", irqReq, 1'b0);
        writeReg(1'b0, ctrlWord(1'b0, ie, 1'b0));
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule